// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides when a small processor core runs, idles or sleeps. A sleep strobe from the core parks it in one of two low-power states. The idle-enable bit picks which one. In idle the CPU clock stops and the peripheral clock keeps running. In sleep both clocks stop. An enabled pending interrupt or a watchdog time-out starts the exit. The controller then raises a wake request and waits for a ready handshake from a separate delay sequencer. When ready arrives, it restarts the CPU clock and pulses a wake-complete strobe. A branch-to-vector flag goes with that strobe when the core should take the interrupt vector.

A watchdog time-out while the core is executing does not wake anything. It produces a one-cycle core reset request instead. The clock-select field only affects the primary-oscillator shutdown request. Only its upper bit matters; the lower bit has no effect. Clock muxing, oscillator models and the delay timing itself live outside this block.

Top module: `pm_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, the block is in run: cpu_clk_en=1, periph_clk_en=1, and wake_req, wake_done, vector_take and core_reset_req are all 0. An asserted rst_n returns the block to run from any state.
- R2: In run, sleep_op with idle_en=1 (and no watchdog time-out) enters idle. From the next cycle, cpu_clk_en=0 and periph_clk_en=1.
- R3: In run, sleep_op with idle_en=0 (and no watchdog time-out) enters sleep. From the next cycle, cpu_clk_en=0, periph_clk_en=0 and posc_off_req=1.
- R4: Outside sleep, posc_off_req equals clk_sel[1] combinationally. clk_sel[0] has no effect.
- R5: In idle or sleep, a bit set in both irq_flag and irq_en starts the exit, and wake_req is 1 from the next cycle. A flag whose enable bit is 0 has no effect.
- R6: While wake_req is 1, cpu_clk_en stays 0 until wake_ready is seen. periph_clk_en is 1 during the wait if the exit began in idle, and 0 if it began in sleep.
- R7: wake_ready sampled while wake_req is 1 returns the block to run in the next cycle. wake_done is 1 for exactly that one cycle. wake_ready at any other time is ignored.
- R8: vector_take is 1 together with wake_done only if the exit was caused by an interrupt and gie was 1 in the cycle the exit began.
- R9: A watchdog time-out in idle or sleep starts the exit, with no core_reset_req. A time-out in run gives a one-cycle core_reset_req in the next cycle, the block stays in run, and a sleep_op in the same cycle is dropped.
- R10: If a watchdog time-out and an enabled interrupt start the exit in the same cycle, the watchdog is the cause and vector_take stays 0.
- R11: sleep_op while in idle, sleep or the wake wait is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_op | input | 1 | Sleep instruction strobe from the core |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep |
| clk_sel | input | 2 | System clock select; bit 1 set means internal oscillator |
| irq_flag | input | N_IRQ | Pending interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wake_ready | input | 1 | Wake delay elapsed, from the delay sequencer |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| posc_off_req | output | 1 | Request to shut down the primary oscillator |
| wake_req | output | 1 | Exit in progress; the delay sequencer runs while this is high |
| wake_done | output | 1 | One-cycle strobe on return to run |
| vector_take | output | 1 | Branch to the interrupt vector, valid with wake_done |
| core_reset_req | output | 1 | One-cycle reset request from a watchdog time-out in run |

## Verification
posc_off_req is combinational on clk_sel and is due in the same cycle. Every other result follows from the state register, so it appears one clock after the edge that samples its cause. A state change seen at one posedge shows on the clock enables and wake_req after that edge. A wake_ready sampled at one edge gives wake_done and vector_take in the cycle after it. A time-out in run gives core_reset_req in the next cycle. The bench changes inputs just after a falling edge and compares at falling edges. A reference model is stepped at each rising edge, so every output is checked exactly one edge after its cause.

// File: rtl/pm_ctrl.sv
module pm_ctrl #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_op,
  input  logic             idle_en,
  input  logic [1:0]       clk_sel,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             wdt_timeout,
  input  logic             wake_ready,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             posc_off_req,
  output logic             wake_req,
  output logic             wake_done,
  output logic             vector_take,
  output logic             core_reset_req
);

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_SLEEP, S_WAKE} state_t;

  state_t st, st_nx;
  logic   from_idle;
  logic   vec_pend;

  wire irq_hit  = |(irq_flag & irq_en);
  wire parked   = (st == S_IDLE) || (st == S_SLEEP);
  wire exit_go  = parked && (wdt_timeout || irq_hit);
  wire wake_fin = (st == S_WAKE) && wake_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_RUN:   if (!wdt_timeout && sleep_op) st_nx = idle_en ? S_IDLE : S_SLEEP;
      S_IDLE,
      S_SLEEP: if (exit_go) st_nx = S_WAKE;
      S_WAKE:  if (wake_ready) st_nx = S_RUN;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_RUN;
      from_idle      <= 1'b0;
      vec_pend       <= 1'b0;
      wake_done      <= 1'b0;
      vector_take    <= 1'b0;
      core_reset_req <= 1'b0;
    end else begin
      st             <= st_nx;
      wake_done      <= wake_fin;
      vector_take    <= wake_fin && vec_pend;
      core_reset_req <= (st == S_RUN) && wdt_timeout;
      if (exit_go) begin
        from_idle <= (st == S_IDLE);
        vec_pend  <= !wdt_timeout && gie;
      end
    end
  end

  assign cpu_clk_en    = (st == S_RUN);
  assign periph_clk_en = (st == S_RUN) || (st == S_IDLE) || ((st == S_WAKE) && from_idle);
  assign posc_off_req  = (st == S_SLEEP) || (clk_sel inside {2'b10, 2'b11});
  assign wake_req      = (st == S_WAKE);

endmodule

// File: rtl/pm_ctrl_checker.sv
module pm_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic wdt_timeout,
  input logic wake_ready,
  input logic cpu_clk_en,
  input logic periph_clk_en,
  input logic posc_off_req,
  input logic wake_req,
  input logic wake_done,
  input logic vector_take,
  input logic core_reset_req
);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

  assert_done_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> cpu_clk_en);

  assert_vector_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vector_take |-> wake_done);

  assert_cpu_waits_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ready) |=> !cpu_clk_en);

  assert_cpu_restart_marked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_done);

  assert_reset_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_req |-> ($past(wdt_timeout) && $past(cpu_clk_en)));

  assert_sleep_stops_posc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !periph_clk_en && !wake_req) |-> posc_off_req);

endmodule

bind pm_ctrl pm_ctrl_checker u_pm_ctrl_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .wdt_timeout    (wdt_timeout),
  .wake_ready     (wake_ready),
  .cpu_clk_en     (cpu_clk_en),
  .periph_clk_en  (periph_clk_en),
  .posc_off_req   (posc_off_req),
  .wake_req       (wake_req),
  .wake_done      (wake_done),
  .vector_take    (vector_take),
  .core_reset_req (core_reset_req)
);

// File: tb/pm_ctrl_bench.sv
module pm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_op = 1'b0, idle_en = 1'b0, gie = 1'b0, wdt_timeout = 1'b0, wake_ready = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic cpu_clk_en, periph_clk_en, posc_off_req, wake_req, wake_done, vector_take, core_reset_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_ctrl #(.N_IRQ(N_IRQ)) u_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op), .idle_en(idle_en), .clk_sel(clk_sel),
    .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout),
    .wake_ready(wake_ready), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .posc_off_req(posc_off_req), .wake_req(wake_req), .wake_done(wake_done),
    .vector_take(vector_take), .core_reset_req(core_reset_req)
  );

  // Reference model: 0 run, 1 idle, 2 sleep, 3 waiting for ready
  int m_mode = 0;
  bit m_from_idle = 0, m_vec_pend = 0, m_done = 0, m_vec = 0, m_rreq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_from_idle = 0; m_vec_pend = 0; m_done = 0; m_vec = 0; m_rreq = 0;
    end else begin
      m_done = 0; m_vec = 0; m_rreq = 0;
      if (m_mode == 0) begin
        if (wdt_timeout) m_rreq = 1;
        else if (sleep_op) m_mode = idle_en ? 1 : 2;
      end else if (m_mode == 1 || m_mode == 2) begin
        if (wdt_timeout || (irq_flag & irq_en) != 0) begin
          m_from_idle = (m_mode == 1);
          m_vec_pend = !wdt_timeout && gie;
          m_mode = 3;
        end
      end else if (wake_ready) begin
        m_mode = 0; m_done = 1; m_vec = m_vec_pend;
      end
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2", "cpu_clk_en", cpu_clk_en, m_mode == 0);
      chk("R6", "periph_clk_en", periph_clk_en, m_mode == 0 || m_mode == 1 || (m_mode == 3 && m_from_idle));
      chk("R4", "posc_off_req", posc_off_req, m_mode == 2 || clk_sel[1]);
      chk("R5", "wake_req", wake_req, m_mode == 3);
      chk("R7", "wake_done", wake_done, m_done);
      chk("R8", "vector_take", vector_take, m_vec);
      chk("R9", "core_reset_req", core_reset_req, m_rreq);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    #1 rst_n = 1;
    cyc(1);
    chk("R1", "cpu after reset", cpu_clk_en, 1'b1);
    chk("R1", "periph after reset", periph_clk_en, 1'b1);
    chk("R1", "wake_req after reset", wake_req, 1'b0);
    #1 clk_sel = 2'b01;
    cyc(1); chk("R4", "posc sel01", posc_off_req, 1'b0);
    #1 clk_sel = 2'b10;
    cyc(1); chk("R4", "posc sel10", posc_off_req, 1'b1);
    #1 clk_sel = 2'b00; idle_en = 1; sleep_op = 1;
    cyc(1);
    chk("R2", "idle cpu", cpu_clk_en, 1'b0);
    chk("R2", "idle periph", periph_clk_en, 1'b1);
    #1 sleep_op = 0; irq_flag = 8'h04; irq_en = 8'h00; gie = 1;
    cyc(2); chk("R5", "masked flag ignored", wake_req, 1'b0);
    #1 irq_en = 8'h04;
    cyc(1); chk("R5", "enabled flag wakes", wake_req, 1'b1);
    #1 irq_flag = 0;
    cyc(3);
    chk("R6", "cpu held during wait", cpu_clk_en, 1'b0);
    chk("R6", "periph on during idle wait", periph_clk_en, 1'b1);
    #1 wake_ready = 1;
    cyc(1);
    chk("R7", "done pulse", wake_done, 1'b1);
    chk("R8", "vector with gie", vector_take, 1'b1);
    #1 wake_ready = 0;
    cyc(1); chk("R7", "done one cycle", wake_done, 1'b0);
    #1 idle_en = 0; sleep_op = 1;
    cyc(1);
    chk("R3", "sleep cpu", cpu_clk_en, 1'b0);
    chk("R3", "sleep periph", periph_clk_en, 1'b0);
    chk("R3", "sleep posc", posc_off_req, 1'b1);
    #1 sleep_op = 0; gie = 0; irq_flag = 8'h04;
    cyc(1);
    chk("R6", "periph off in sleep wait", periph_clk_en, 1'b0);
    #1 irq_flag = 0; wake_ready = 1;
    cyc(1); chk("R8", "no vector without gie", vector_take, 1'b0);
    #1 wake_ready = 0; wdt_timeout = 1; sleep_op = 1;
    cyc(1);
    chk("R9", "reset req in run", core_reset_req, 1'b1);
    chk("R9", "stays in run", cpu_clk_en, 1'b1);
    #1 wdt_timeout = 0; sleep_op = 0;
    cyc(1); chk("R9", "reset req one cycle", core_reset_req, 1'b0);
    #1 sleep_op = 1;
    cyc(1);
    #1 sleep_op = 0; wdt_timeout = 1;
    cyc(1);
    chk("R9", "wdt wakes from sleep", wake_req, 1'b1);
    chk("R9", "no reset req from sleep", core_reset_req, 1'b0);
    #1 wdt_timeout = 0; wake_ready = 1;
    cyc(1); chk("R9", "wdt wake completes", wake_done, 1'b1);
    #1 wake_ready = 0; idle_en = 1; sleep_op = 1;
    cyc(1);
    #1 sleep_op = 0; gie = 1; wdt_timeout = 1; irq_flag = 8'h04;
    cyc(1); chk("R10", "joint wake", wake_req, 1'b1);
    #1 wdt_timeout = 0; irq_flag = 0; wake_ready = 1;
    cyc(1);
    chk("R10", "wdt cause no vector", vector_take, 1'b0);
    chk("R10", "done", wake_done, 1'b1);
    #1 wake_ready = 0; sleep_op = 1;
    cyc(1);
    #1 idle_en = 0; sleep_op = 1;
    cyc(1);
    #1 sleep_op = 0;
    cyc(1); chk("R11", "sleep_op in idle ignored", periph_clk_en, 1'b1);
    #1 wake_ready = 1;
    cyc(1); chk("R7", "stray ready ignored", cpu_clk_en, 1'b0);
    #1 wake_ready = 0; rst_n = 0;
    cyc(1);
    #1 rst_n = 1;
    cyc(1); chk("R1", "reset from idle", cpu_clk_en, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      #1;
      sleep_op    = ($urandom_range(0, 7) == 0);
      idle_en     = $urandom_range(0, 1);
      clk_sel     = 2'($urandom_range(0, 3));
      irq_flag    = ($urandom_range(0, 9) == 0) ? N_IRQ'($urandom) : '0;
      irq_en      = N_IRQ'($urandom);
      gie         = $urandom_range(0, 1);
      wdt_timeout = ($urandom_range(0, 19) == 0);
      wake_ready  = ($urandom_range(0, 3) == 0);
      cyc(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected below 20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule